// File: doc/BRIEF.md
# Graphic LCD Column Driver Bus Interface

This block is the processor-facing half of a 64-column graphic LCD segment driver. A host talks to it over an 8-bit bidirectional data bus. Three control lines go with the bus: a register select (`rs`), a direction line (`rw`) and an enable strobe (`en`). Three chip-select lines of mixed polarity and a synchronous reset complete the interface. Inside, the block keeps a display memory of 64 columns by 8 pages of 8-bit bytes. It also holds a column counter that advances by itself, a page register, a display start-line register, a display-enable flag and a busy timer.

Writes act on the falling edge of `en`. The block samples `en` with its internal clock, holds the bus values seen while `en` was high, and executes them on the clock edge at which `en` is first seen low. Reads are combinational: while the chip is selected, `rw` is 1 and `en` is high, the block drives either the status byte or the display byte at the current page and column. After each accepted write, a busy interval of `BUSY_CYC` clocks follows, and the block accepts no instruction during it. The start line and the display-enable flag are brought out for the scan logic that is not part of this block.

Top module: `glcd_col_if`

## Requirements
- R1: The chip responds only when `cs1_n`=0, `cs2_n`=0 and `cs3`=1. With any other combination, a bus cycle changes no register and no memory byte, and the bus is not driven.
- R2: A write takes effect on the clock edge at which `en` is first sampled low after being high. It uses the `rs`, `rw` and data values held while `en` was high. Between such edges, `top_line` and `disp_on` do not change.
- R3: A status read (`rs`=0, `rw`=1) returns busy in bit 7, 0 in bit 6, the display-enable flag in bit 5, the reset flag in bit 4, and zeros in bits 3:0.
- R4: Instruction byte `0011111d` (`rs`=0, `rw`=0) sets `disp_on` to `d`.
- R5: Instruction byte `01cccccc` loads the column counter with `cccccc`. A data write (`rs`=1, `rw`=0) stores the byte at the current page and column, then advances the column by 1. The column wraps from 63 to 0.
- R6: A data read (`rs`=1, `rw`=1) drives the byte at the current page and column while `en` is high. The column advances by 1 when `en` falls.
- R7: Instruction byte `10111ppp` selects page `ppp`. Different pages hold independent bytes at the same column.
- R8: Instruction byte `11llllll` loads the start line `llllll` (0 to 63) and drives it on `top_line`.
- R9: After each accepted write (any recognised instruction or a data write), busy reads as 1 for `BUSY_CYC` clocks. Writes that fall inside that window are ignored.
- R10: While `rst` is 1, the column, page and start line are 0, the display is off, and the status reset bit reads 1. Only status reads are served; other accesses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock sampling the bus |
| rst | input | 1 | Synchronous active-high reset |
| cs1_n | input | 1 | Chip select, active low |
| cs2_n | input | 1 | Chip select, active low |
| cs3 | input | 1 | Chip select, active high |
| rs | input | 1 | 0 = instruction/status, 1 = display data |
| rw | input | 1 | 0 = write, 1 = read |
| en | input | 1 | Bus enable strobe |
| db | inout | 8 | Bidirectional data bus |
| top_line | output | 6 | Display start line |
| disp_on | output | 1 | Display enable flag |

## Verification
The bench writes and reads data at several page and column pairs. This separates a correct page and column address from one that is off by a column or ignores the page. A run of writes across column 63, followed by reads starting there, tells a proper wrap from overflow into the next page. Writes made with a wrong chip-select combination, during the busy window, or while reset is held are each followed by accesses whose address shows whether the stray write landed. Status reads taken just after a write, once ready, and under reset tell the busy, display and reset bits apart.

// File: rtl/glcd_pkg.sv
package glcd_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_DISP,
        OP_SETY,
        OP_SETX,
        OP_LINE,
        OP_STAT,
        OP_WDATA,
        OP_RDATA
    } op_e;

    typedef struct packed {
        logic       rs;
        logic       rw;
        logic [7:0] db;
    } bus_cap_t;

    function automatic op_e decode_op(bus_cap_t c);
        op_e o;
        o = OP_NONE;
        if (c.rs) begin
            o = c.rw ? OP_RDATA : OP_WDATA;
        end else if (c.rw) begin
            o = OP_STAT;
        end else if (c.db[7:6] == 2'b01) begin
            o = OP_SETY;
        end else if (c.db[7:6] == 2'b11) begin
            o = OP_LINE;
        end else if (c.db[7:3] == 5'b10111) begin
            o = OP_SETX;
        end else if (c.db[7:1] == 7'b0011111) begin
            o = OP_DISP;
        end
        return o;
    endfunction

    function automatic logic op_is_write(op_e o);
        return (o == OP_DISP) || (o == OP_SETY) || (o == OP_SETX) ||
               (o == OP_LINE) || (o == OP_WDATA);
    endfunction

    function automatic logic [7:0] pack_status(logic busy, logic on, logic rflag);
        return {busy, 1'b0, on, rflag, 4'b0000};
    endfunction

endpackage

// File: rtl/glcd_strobe.sv
module glcd_strobe
    import glcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       sel,
    input  logic       rs,
    input  logic       rw,
    input  logic [7:0] db_in,
    output logic       fall,
    output bus_cap_t   cap
);
    logic e_q;
    logic sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            e_q   <= 1'b0;
            sel_q <= 1'b0;
            cap   <= '0;
        end else begin
            e_q <= en;
            if (en) begin
                sel_q  <= sel;
                cap.rs <= rs;
                cap.rw <= rw;
                cap.db <= db_in;
            end
        end
    end

    assign fall = e_q && !en && sel_q;
endmodule

// File: rtl/glcd_ram.sv
module glcd_ram #(
    parameter int COLS  = 64,
    parameter int PAGES = 8,
    parameter int DW    = 8
) (
    input  logic                           clk,
    input  logic                           we,
    input  logic [$clog2(COLS*PAGES)-1:0]  addr,
    input  logic [DW-1:0]                  wdata,
    output logic [DW-1:0]                  rdata
);
    localparam int DEPTH = COLS * PAGES;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/glcd_ctrl.sv
module glcd_ctrl
    import glcd_pkg::*;
#(
    parameter int COLS     = 64,
    parameter int PAGES    = 8,
    parameter int BUSY_CYC = 8,
    localparam int YW = $clog2(COLS),
    localparam int PW = $clog2(PAGES),
    localparam int LW = $clog2(PAGES * 8)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fall,
    input  bus_cap_t      cap,
    output logic [YW-1:0] col,
    output logic [PW-1:0] page,
    output logic [LW-1:0] line,
    output logic          disp_on,
    output logic          busy,
    output logic          rst_flag,
    output logic          ram_we,
    output logic          acc_write
);
    localparam int CW = $clog2(BUSY_CYC + 1);

    op_e           op;
    logic [CW-1:0] busy_cnt;
    logic          take;
    logic [YW-1:0] col_next;

    assign op        = decode_op(cap);
    assign busy      = (busy_cnt != '0);
    assign take      = fall && !busy;
    assign acc_write = take && op_is_write(op);
    assign ram_we    = take && (op == OP_WDATA);
    assign col_next  = (col == YW'(COLS - 1)) ? '0 : col + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            col      <= '0;
            page     <= '0;
            line     <= '0;
            disp_on  <= 1'b0;
            busy_cnt <= '0;
            rst_flag <= 1'b1;
        end else begin
            rst_flag <= 1'b0;
            if (acc_write) begin
                busy_cnt <= CW'(BUSY_CYC);
            end else if (busy) begin
                busy_cnt <= busy_cnt - 1'b1;
            end
            if (take) begin
                case (op)
                    OP_DISP:  disp_on <= cap.db[0];
                    OP_SETY:  col     <= cap.db[YW-1:0];
                    OP_SETX:  page    <= cap.db[PW-1:0];
                    OP_LINE:  line    <= cap.db[LW-1:0];
                    OP_WDATA: col     <= col_next;
                    OP_RDATA: col     <= col_next;
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/glcd_col_if.sv
module glcd_col_if
    import glcd_pkg::*;
#(
    parameter int COLS     = 64,
    parameter int PAGES    = 8,
    parameter int BUSY_CYC = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs1_n,
    input  logic       cs2_n,
    input  logic       cs3,
    input  logic       rs,
    input  logic       rw,
    input  logic       en,
    inout  wire  [7:0] db,
    output logic [5:0] top_line,
    output logic       disp_on
);
    localparam int YW = $clog2(COLS);
    localparam int PW = $clog2(PAGES);
    localparam int LW = $clog2(PAGES * 8);
    localparam int AW = $clog2(COLS * PAGES);

    logic          sel;
    logic          oe;
    logic          fall;
    bus_cap_t      cap;
    logic [YW-1:0] col;
    logic [PW-1:0] page;
    logic [LW-1:0] line;
    logic          busy;
    logic          rst_flag;
    logic          ram_we;
    logic          acc_write;
    logic [7:0]    ram_q;
    logic [7:0]    rd_data;

    assign sel = !cs1_n && !cs2_n && cs3;
    assign oe  = sel && rw && en;

    glcd_strobe i_strobe (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .sel   (sel),
        .rs    (rs),
        .rw    (rw),
        .db_in (db),
        .fall  (fall),
        .cap   (cap)
    );

    glcd_ctrl #(.COLS(COLS), .PAGES(PAGES), .BUSY_CYC(BUSY_CYC)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .fall      (fall),
        .cap       (cap),
        .col       (col),
        .page      (page),
        .line      (line),
        .disp_on   (disp_on),
        .busy      (busy),
        .rst_flag  (rst_flag),
        .ram_we    (ram_we),
        .acc_write (acc_write)
    );

    glcd_ram #(.COLS(COLS), .PAGES(PAGES), .DW(8)) i_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (AW'({page, col})),
        .wdata (cap.db),
        .rdata (ram_q)
    );

    assign rd_data  = rs ? ram_q : pack_status(busy, disp_on, rst_flag);
    assign db       = oe ? rd_data : 8'bzzzz_zzzz;
    assign top_line = 6'(line);
endmodule

// File: rtl/glcd_col_if_chk.sv
module glcd_col_if_chk (
    input logic       clk,
    input logic       rst,
    input logic       oe,
    input logic       rs,
    input logic [7:0] rd_data,
    input logic       fall,
    input logic       busy,
    input logic       acc_write,
    input logic [5:0] top_line,
    input logic       disp_on
);
    // R2: outputs move only on a falling-strobe edge
    a_r2_change_on_fall: assert property (@(posedge clk) disable iff (rst)
        !fall |=> ($stable(top_line) && $stable(disp_on)));

    // R3: reserved status bits read zero
    a_r3_status_zero_bits: assert property (@(posedge clk)
        (oe && !rs) |-> (rd_data[6] == 1'b0 && rd_data[3:0] == 4'h0));

    // R9: an accepted write opens the busy window
    a_r9_busy_after_write: assert property (@(posedge clk) disable iff (rst)
        acc_write |=> busy);

    // R9: strobes during busy leave the registers alone
    a_r9_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        (fall && busy) |=> ($stable(top_line) && $stable(disp_on)));

    // R10: reset clears line and display flag
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (top_line == 6'd0 && !disp_on));

    // R10: no write is accepted in reset
    a_r10_no_write_in_reset: assert property (@(posedge clk)
        rst |-> !acc_write);
endmodule

bind glcd_col_if glcd_col_if_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .oe        (oe),
    .rs        (rs),
    .rd_data   (rd_data),
    .fall      (fall),
    .busy      (busy),
    .acc_write (acc_write),
    .top_line  (top_line),
    .disp_on   (disp_on)
);

// File: tb/test_glcd_col_if.sv
`timescale 1ns/100ps
module test_glcd_col_if;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs1_n = 1'b1, cs2_n = 1'b1, cs3 = 1'b0;
    logic       rs = 1'b0, rw = 1'b0, en = 1'b0;
    logic [7:0] db_drv = 8'h00;
    logic       db_oe = 1'b0;
    wire  [7:0] db;
    logic [5:0] top_line;
    logic       disp_on;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    assign db = db_oe ? db_drv : 8'bzzzz_zzzz;

    always #2.5 clk = ~clk;

    glcd_col_if i_glcd_col_if (
        .clk(clk), .rst(rst), .cs1_n(cs1_n), .cs2_n(cs2_n), .cs3(cs3),
        .rs(rs), .rw(rw), .en(en), .db(db),
        .top_line(top_line), .disp_on(disp_on)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic r, input logic [7:0] d, input logic good_sel = 1'b1);
        @(negedge clk);
        cs1_n = 1'b0; cs2_n = 1'b0; cs3 = good_sel;
        rs = r; rw = 1'b0; db_drv = d; db_oe = 1'b1; en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        db_oe = 1'b0; cs3 = 1'b0;
    endtask

    task automatic bus_rd(input logic r, output logic [7:0] d);
        @(negedge clk);
        cs1_n = 1'b0; cs2_n = 1'b0; cs3 = 1'b1;
        rs = r; rw = 1'b1; db_oe = 1'b0; en = 1'b1;
        @(negedge clk);
        d = db;
        en = 1'b0;
        @(negedge clk);
        cs3 = 1'b0; rw = 1'b0;
    endtask

    task automatic wait_ready();
        logic [7:0] s;
        for (int i = 0; i < 40; i++) begin
            bus_rd(1'b0, s);
            if (!s[7]) break;
        end
    endtask

    task automatic cmd(input logic [7:0] d);
        bus_wr(1'b0, d);
        wait_ready();
    endtask

    task automatic dwr(input logic [7:0] d);
        bus_wr(1'b1, d);
        wait_ready();
    endtask

    task automatic t_reset_state();
        logic [7:0] s;
        bus_rd(1'b0, s);
        check8("R10 status under reset", s, 8'h10);
        check8("R10 top_line under reset", {2'b0, top_line}, 8'h00);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        bus_rd(1'b0, s);
        check8("R3 status after reset", s, 8'h00);
    endtask

    task automatic t_display_onoff();
        logic [7:0] s;
        bus_wr(1'b0, 8'h3F);
        bus_rd(1'b0, s);
        check8("R9 busy bit right after write", s & 8'h80, 8'h80);
        wait_ready();
        bus_rd(1'b0, s);
        check8("R3 R4 status with display on", s, 8'h20);
        check8("R4 disp_on set", {7'b0, disp_on}, 8'h01);
        cmd(8'h3E);
        check8("R4 disp_on cleared", {7'b0, disp_on}, 8'h00);
        cmd(8'h3F);
    endtask

    task automatic t_start_line();
        cmd(8'hC0 | 8'd45);
        check8("R8 start line 45", {2'b0, top_line}, 8'd45);
        cmd(8'hFF);
        check8("R8 start line 63", {2'b0, top_line}, 8'd63);
    endtask

    task automatic t_write_read();
        logic [7:0] d;
        cmd(8'hB8 | 8'd2); cmd(8'h40 | 8'd10);
        dwr(8'hA1); dwr(8'hA2); dwr(8'hA3);
        cmd(8'hB8 | 8'd5); cmd(8'h40 | 8'd10);
        dwr(8'h5C);
        cmd(8'hB8 | 8'd2); cmd(8'h40 | 8'd10);
        bus_rd(1'b1, d); check8("R5 R6 page2 col10", d, 8'hA1);
        bus_rd(1'b1, d); check8("R6 auto advance col11", d, 8'hA2);
        bus_rd(1'b1, d); check8("R6 auto advance col12", d, 8'hA3);
        cmd(8'hB8 | 8'd5); cmd(8'h40 | 8'd10);
        bus_rd(1'b1, d); check8("R7 page5 independent", d, 8'h5C);
    endtask

    task automatic t_wrap();
        logic [7:0] d;
        cmd(8'hB8 | 8'd1); cmd(8'h40 | 8'd63);
        dwr(8'h11); dwr(8'h22);
        cmd(8'h40 | 8'd63);
        bus_rd(1'b1, d); check8("R5 col63 data", d, 8'h11);
        bus_rd(1'b1, d); check8("R5 wrap to col0", d, 8'h22);
    endtask

    task automatic t_deselect();
        logic [7:0] d;
        cmd(8'hB8 | 8'd3); cmd(8'h40 | 8'd20);
        bus_wr(1'b1, 8'h5A, 1'b0);
        bus_wr(1'b0, 8'h40 | 8'd40, 1'b0);
        bus_wr(1'b0, 8'hC7, 1'b0);
        check8("R1 deselected line write ignored", {2'b0, top_line}, 8'd63);
        dwr(8'hC3);
        cmd(8'h40 | 8'd20);
        bus_rd(1'b1, d); check8("R1 deselected data write ignored", d, 8'hC3);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] d;
        cmd(8'hB8 | 8'd4);
        bus_wr(1'b0, 8'h40 | 8'd5);
        bus_wr(1'b0, 8'h40 | 8'd30);
        bus_wr(1'b0, 8'hC9);
        check8("R9 line write during busy ignored", {2'b0, top_line}, 8'd63);
        wait_ready();
        dwr(8'hAA);
        cmd(8'h40 | 8'd5);
        bus_rd(1'b1, d); check8("R9 column write during busy ignored", d, 8'hAA);
    endtask

    task automatic t_reset_mid();
        logic [7:0] s;
        cmd(8'hC0 | 8'd20); cmd(8'hB8 | 8'd6); cmd(8'h40 | 8'd7);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_rd(1'b0, s);
        check8("R10 status during reset", s, 8'h10);
        bus_wr(1'b0, 8'hC5);
        check8("R10 line write in reset ignored", {2'b0, top_line}, 8'd0);
        check8("R10 display off in reset", {7'b0, disp_on}, 8'h00);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        dwr(8'h77);
        cmd(8'hB8); cmd(8'h40);
        bus_rd(1'b1, s);
        check8("R10 page and column cleared", s, 8'h77);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset_state();
        t_display_onoff();
        t_start_line();
        t_write_read();
        t_wrap();
        t_deselect();
        t_busy_ignore();
        t_reset_mid();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule